// File: doc/BRIEF.md
# Bulk Transfer Command Chunker

This block is a small DMA sequencer placed in front of a board-to-board copy port. The host hands it one bulk copy request: a local buffer address, a remote buffer address, the remote node's identifier, a byte length and a direction (read or write). The port itself accepts only transactions of at most 1 KiB of payload. The port is programmed by loading five parallel parameter FIFOs with one transaction's settings. The sequencer therefore splits the bulk request into as many port commands as it needs. A 10 MB copy, for example, becomes roughly ten thousand commands.

For each command the sequencer writes five words in the same cycle: local address, remote address, node ID, byte count and opcode. Every command carries the smaller of the remaining length and 1 KiB. Both addresses then move forward by that amount. The sequencer waits whenever any of the five FIFOs reports full. When the last command has been written, it raises a one-cycle completion pulse. A busy flag covers the whole transfer. A request that arrives while the sequencer is busy is dropped, and a sticky error flag records the drop.

Top module: `xfer_chunker`

## Requirements
- R1: After reset, `busy`, `done`, `err_flag` and `cmd_push` are all low.
- R2: Every command carries a byte count of min(remaining bytes, 1024). The count is never zero and never above 1024.
- R3: The first command of a transfer carries the requested local and remote addresses. Each later command carries both addresses advanced by the byte count of the command before it. The node ID and the opcode (0 = read, 1 = write, taken from `req_dir`) are repeated unchanged in every command.
- R4: A request of L bytes produces exactly ceil(L/1024) commands, and their byte counts add up to L.
- R5: `cmd_push` is high in a cycle only if every bit of `fifo_full` was low at the clock edge that began that cycle. A stall neither loses a command nor repeats one. Each `fifo_full` bit must therefore assert while its FIFO still has one free entry.
- R6: A zero-length request produces no command. `done` is high in the cycle after the accepting edge, with `busy` also high in that cycle, and both are low one cycle later.
- R7: `done` is high for exactly one cycle, in the same cycle as the final command's push. `busy` is high from the cycle after the accepting edge through the `done` cycle, and `cmd_push` is never high while `busy` is low.
- R8: A request presented while `busy` is high has no effect on the command stream and sets `err_flag`. `err_flag` then stays high until reset, and later requests are still accepted.
- R9: While `fifo_full` stays low, the commands of one transfer are pushed in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bulk request strobe, taken only while idle |
| req_dir | input | 1 | Direction: 0 read, 1 write |
| req_local_addr | input | AW | Start address in the local buffer |
| req_remote_addr | input | AW | Start address in the remote buffer |
| req_node_id | input | IDW | Remote node identifier |
| req_length | input | LW | Total byte length |
| fifo_full | input | 5 | Full flags of the five parameter FIFOs |
| cmd_push | output | 1 | Push strobe common to all five FIFOs |
| cmd_local_addr | output | AW | Local address word of the command |
| cmd_remote_addr | output | AW | Remote address word of the command |
| cmd_node_id | output | IDW | Node ID word of the command |
| cmd_byte_count | output | CW | Byte count word of the command |
| cmd_opcode | output | 1 | Opcode word of the command |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Sticky flag for a request dropped while busy |

## Verification
The bench targets the chunk boundaries: exactly 1024 bytes, 1025 bytes, a single byte, zero bytes, and a length that is not a multiple of 1024. A design with an off-by-one in the minimum or in the last-chunk test would emit an empty or an extra command, or a 1025-byte command. Stall patterns raise a different FIFO full flag on different cycles. A sequencer that ignored one of the flags, or that re-pushed the stalled chunk, would show a push after a full edge or a repeated address. A request placed in the middle of a transfer checks that the stream continues unchanged and that the error flag sets and stays set. The zero-length case checks that completion comes without any command being pushed.

// File: rtl/xfer_chunker_pkg.sv
package xfer_chunker_pkg;

  localparam int NUM_QUEUES = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } xfer_op_t;

endpackage

// File: rtl/xfer_chunk_size.sv
module xfer_chunk_size #(
  parameter int LW        = 32,
  parameter int MAX_CHUNK = 1024,
  parameter int CW        = $clog2(MAX_CHUNK + 1)
) (
  input  logic [LW-1:0] remaining,
  output logic [CW-1:0] chunk,
  output logic          last_chunk
);

  localparam logic [LW-1:0] LIMIT = LW'(MAX_CHUNK);

  always_comb begin
    last_chunk = (remaining <= LIMIT);
    if (last_chunk) chunk = remaining[CW-1:0];
    else            chunk = CW'(MAX_CHUNK);
  end

endmodule

// File: rtl/xfer_seq_ctrl.sv
module xfer_seq_ctrl
  import xfer_chunker_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic zero_len,
  input  logic any_full,
  input  logic last_chunk,
  output logic accept,
  output logic issue,
  output logic busy,
  output logic done,
  output logic err_flag
);

  seq_state_t state_q, state_d;
  logic       reject;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = zero_len ? ST_DONE : ST_ISSUE;
      ST_ISSUE: begin
        if (any_full)        state_d = ST_WAIT;
        else if (last_chunk) state_d = ST_DONE;
      end
      ST_WAIT:  if (!any_full) state_d = ST_ISSUE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign accept = (state_q == ST_IDLE) && req_valid;
  assign issue  = (state_q == ST_ISSUE) && !any_full;
  assign reject = (state_q != ST_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      state_q  <= state_d;
      busy     <= (state_d != ST_IDLE);
      done     <= (state_d == ST_DONE);
      err_flag <= err_flag | reject;
    end
  end

endmodule

// File: rtl/xfer_cursor.sv
module xfer_cursor #(
  parameter int AW  = 32,
  parameter int IDW = 16,
  parameter int LW  = 32,
  parameter int CW  = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           advance,
  input  logic [AW-1:0]  in_local,
  input  logic [AW-1:0]  in_remote,
  input  logic [IDW-1:0] in_node,
  input  logic [LW-1:0]  in_length,
  input  logic           in_dir,
  input  logic [CW-1:0]  chunk,
  output logic [AW-1:0]  cur_local,
  output logic [AW-1:0]  cur_remote,
  output logic [IDW-1:0] cur_node,
  output logic           cur_dir,
  output logic [LW-1:0]  remaining
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_local  <= '0;
      cur_remote <= '0;
      cur_node   <= '0;
      cur_dir    <= 1'b0;
      remaining  <= '0;
    end else if (load) begin
      cur_local  <= in_local;
      cur_remote <= in_remote;
      cur_node   <= in_node;
      cur_dir    <= in_dir;
      remaining  <= in_length;
    end else if (advance) begin
      cur_local  <= cur_local + AW'(chunk);
      cur_remote <= cur_remote + AW'(chunk);
      remaining  <= remaining - LW'(chunk);
    end
  end

endmodule

// File: rtl/xfer_cmd_out.sv
module xfer_cmd_out #(
  parameter int AW  = 32,
  parameter int IDW = 16,
  parameter int CW  = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue,
  input  logic [AW-1:0]  cur_local,
  input  logic [AW-1:0]  cur_remote,
  input  logic [IDW-1:0] cur_node,
  input  logic           cur_dir,
  input  logic [CW-1:0]  chunk,
  output logic           cmd_push,
  output logic [AW-1:0]  cmd_local_addr,
  output logic [AW-1:0]  cmd_remote_addr,
  output logic [IDW-1:0] cmd_node_id,
  output logic [CW-1:0]  cmd_byte_count,
  output logic           cmd_opcode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_push        <= 1'b0;
      cmd_local_addr  <= '0;
      cmd_remote_addr <= '0;
      cmd_node_id     <= '0;
      cmd_byte_count  <= '0;
      cmd_opcode      <= 1'b0;
    end else begin
      cmd_push <= issue;
      if (issue) begin
        cmd_local_addr  <= cur_local;
        cmd_remote_addr <= cur_remote;
        cmd_node_id     <= cur_node;
        cmd_byte_count  <= chunk;
        cmd_opcode      <= cur_dir;
      end
    end
  end

endmodule

// File: rtl/xfer_chunker.sv
module xfer_chunker
  import xfer_chunker_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDW       = 16,
  parameter int LW        = 32,
  parameter int MAX_CHUNK = 1024,
  parameter int CW        = $clog2(MAX_CHUNK + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_dir,
  input  logic [AW-1:0]         req_local_addr,
  input  logic [AW-1:0]         req_remote_addr,
  input  logic [IDW-1:0]        req_node_id,
  input  logic [LW-1:0]         req_length,
  input  logic [NUM_QUEUES-1:0] fifo_full,
  output logic                  cmd_push,
  output logic [AW-1:0]         cmd_local_addr,
  output logic [AW-1:0]         cmd_remote_addr,
  output logic [IDW-1:0]        cmd_node_id,
  output logic [CW-1:0]         cmd_byte_count,
  output logic                  cmd_opcode,
  output logic                  busy,
  output logic                  done,
  output logic                  err_flag
);

  logic           accept, issue, last_chunk, any_full;
  logic [CW-1:0]  chunk;
  logic [AW-1:0]  cur_local, cur_remote;
  logic [IDW-1:0] cur_node;
  logic           cur_dir;
  logic [LW-1:0]  remaining;

  // Stall if any one of the parameter queues has no room.
  logic [NUM_QUEUES:0] full_chain;
  assign full_chain[0] = 1'b0;
  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_full
    assign full_chain[q+1] = full_chain[q] | fifo_full[q];
  end
  assign any_full = full_chain[NUM_QUEUES];

  xfer_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .zero_len   (req_length == '0),
    .any_full   (any_full),
    .last_chunk (last_chunk),
    .accept     (accept),
    .issue      (issue),
    .busy       (busy),
    .done       (done),
    .err_flag   (err_flag)
  );

  xfer_cursor #(.AW(AW), .IDW(IDW), .LW(LW), .CW(CW)) u_cursor (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .advance    (issue),
    .in_local   (req_local_addr),
    .in_remote  (req_remote_addr),
    .in_node    (req_node_id),
    .in_length  (req_length),
    .in_dir     (req_dir),
    .chunk      (chunk),
    .cur_local  (cur_local),
    .cur_remote (cur_remote),
    .cur_node   (cur_node),
    .cur_dir    (cur_dir),
    .remaining  (remaining)
  );

  xfer_chunk_size #(.LW(LW), .MAX_CHUNK(MAX_CHUNK), .CW(CW)) u_size (
    .remaining  (remaining),
    .chunk      (chunk),
    .last_chunk (last_chunk)
  );

  xfer_cmd_out #(.AW(AW), .IDW(IDW), .CW(CW)) u_out (
    .clk             (clk),
    .rst             (rst),
    .issue           (issue),
    .cur_local       (cur_local),
    .cur_remote      (cur_remote),
    .cur_node        (cur_node),
    .cur_dir         (cur_dir),
    .chunk           (chunk),
    .cmd_push        (cmd_push),
    .cmd_local_addr  (cmd_local_addr),
    .cmd_remote_addr (cmd_remote_addr),
    .cmd_node_id     (cmd_node_id),
    .cmd_byte_count  (cmd_byte_count),
    .cmd_opcode      (cmd_opcode)
  );

endmodule

// File: rtl/xfer_chunker_chk.sv
module xfer_chunker_chk #(
  parameter int NQ        = 5,
  parameter int CW        = 11,
  parameter int MAX_CHUNK = 1024
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [NQ-1:0] fifo_full,
  input logic          cmd_push,
  input logic [CW-1:0] cmd_byte_count,
  input logic          busy,
  input logic          done,
  input logic          err_flag
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !err_flag && !cmd_push));

  p_chunk_cap_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_push |-> (cmd_byte_count != '0 && cmd_byte_count <= CW'(MAX_CHUNK)));

  p_push_space_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_push |-> ($past(fifo_full) == '0));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_push);

  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && busy) |=> err_flag);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

endmodule

bind xfer_chunker xfer_chunker_chk #(
  .NQ(xfer_chunker_pkg::NUM_QUEUES), .CW(CW), .MAX_CHUNK(MAX_CHUNK)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .fifo_full      (fifo_full),
  .cmd_push       (cmd_push),
  .cmd_byte_count (cmd_byte_count),
  .busy           (busy),
  .done           (done),
  .err_flag       (err_flag)
);

// File: tb/test_xfer_chunker.sv
module test_xfer_chunker;

  localparam int AW = 32, IDW = 16, LW = 32, MAXC = 1024, CW = 11;

  typedef struct packed {
    logic [AW-1:0]  la;
    logic [AW-1:0]  ra;
    logic [IDW-1:0] id;
    logic [CW-1:0]  cnt;
    logic           op;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_dir = 1'b0;
  logic [AW-1:0] req_local_addr = '0, req_remote_addr = '0;
  logic [IDW-1:0] req_node_id = '0;
  logic [LW-1:0] req_length = '0;
  logic [4:0] fifo_full = '0;
  logic cmd_push, cmd_opcode, busy, done, err_flag;
  logic [AW-1:0] cmd_local_addr, cmd_remote_addr;
  logic [IDW-1:0] cmd_node_id;
  logic [CW-1:0] cmd_byte_count;

  int total = 0, bad = 0;
  int cyc = 0, push_cnt = 0, first_cyc = -1, last_cyc = -1;
  bit stall_on = 1'b0, finished = 1'b0;
  logic [4:0] full_seen = '0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  xfer_chunker i_xfer_chunker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dir(req_dir),
    .req_local_addr(req_local_addr), .req_remote_addr(req_remote_addr),
    .req_node_id(req_node_id), .req_length(req_length), .fifo_full(fifo_full),
    .cmd_push(cmd_push), .cmd_local_addr(cmd_local_addr),
    .cmd_remote_addr(cmd_remote_addr), .cmd_node_id(cmd_node_id),
    .cmd_byte_count(cmd_byte_count), .cmd_opcode(cmd_opcode),
    .busy(busy), .done(done), .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    full_seen <= fifo_full;
  end

  // Stall pattern driver: raises single queue full flags on varying cycles.
  always @(negedge clk) begin
    if (stall_on && ((cyc % 4) == 1 || (cyc % 4) == 2)) fifo_full = 5'b00001 << (cyc % 5);
    else fifo_full = '0;
  end

  // Monitor: compares each pushed command against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && cmd_push) begin
      exp_t e;
      push_cnt++;
      if (first_cyc < 0) first_cyc = cyc;
      last_cyc = cyc;
      check(full_seen == '0, "R5", "push after full edge", full_seen, 0);
      check(!busy == 1'b0, "R7", "push while idle", busy, 1);
      if (q.size() == 0) begin
        check(1'b0, "R4", "unexpected extra command", push_cnt, 0);
      end else begin
        e = q.pop_front();
        check(cmd_byte_count == e.cnt, "R2", "byte count", cmd_byte_count, e.cnt);
        check(cmd_local_addr == e.la, "R3", "local address", cmd_local_addr, e.la);
        check(cmd_remote_addr == e.ra, "R3", "remote address", cmd_remote_addr, e.ra);
        check(cmd_node_id == e.id && cmd_opcode == e.op, "R3", "node id/opcode",
              {cmd_node_id, cmd_opcode}, {e.id, e.op});
      end
    end
  end

  task automatic run_xfer(input logic [AW-1:0] la, input logic [AW-1:0] ra,
                          input logic [IDW-1:0] id, input logic [LW-1:0] len,
                          input logic dir, input bit intrude, input bit check_rate);
    int n_exp = 0, waited = 0;
    logic [LW-1:0] rem = len;
    logic [AW-1:0] l = la, r = ra;
    while (rem != 0) begin
      logic [CW-1:0] c = (rem > MAXC) ? CW'(MAXC) : rem[CW-1:0];
      q.push_back('{la: l, ra: r, id: id, cnt: c, op: dir});
      l += AW'(c); r += AW'(c); rem -= LW'(c);
      n_exp++;
    end
    push_cnt = 0; first_cyc = -1; last_cyc = -1;
    @(negedge clk);
    req_local_addr = la; req_remote_addr = ra; req_node_id = id;
    req_length = len; req_dir = dir; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R7", "busy after accept", busy, 1);
    if (intrude) begin
      @(negedge clk);
      check(err_flag == 1'b0, "R8", "err before intrusion", err_flag, 0);
      req_local_addr = 32'hDEAD_0000; req_remote_addr = 32'hBEEF_0000;
      req_node_id = 16'h7777; req_length = 32'd99; req_dir = ~dir; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R7", "done reached", done, 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7", "done one cycle then idle",
          {done, busy}, 0);
    check(q.size() == 0, "R4", "missing commands", q.size(), 0);
    check(push_cnt == n_exp, "R4", "command count", push_cnt, n_exp);
    if (check_rate && n_exp > 0)
      check(last_cyc - first_cyc == n_exp - 1, "R9", "back-to-back spacing",
            last_cyc - first_cyc, n_exp - 1);
    if (intrude)
      check(err_flag == 1'b1, "R8", "err set by intrusion", err_flag, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, err_flag, cmd_push} == 4'b0, "R1", "reset outputs",
          {busy, done, err_flag, cmd_push}, 0);

    run_xfer(32'h0000_1000, 32'h8000_0000, 16'h0012, 32'd1024, 1'b1, 0, 1); // R2 exact
    run_xfer(32'h0000_2000, 32'h9000_0100, 16'h0345, 32'd1025, 1'b0, 0, 1); // R2 1025
    run_xfer(32'h0001_0000, 32'h0002_0000, 16'hABCD, 32'd5000, 1'b1, 0, 1); // R9
    run_xfer(32'h0000_0001, 32'h0000_0003, 16'h0001, 32'd1, 1'b0, 0, 1);    // R2 one byte

    stall_on = 1'b1;                                                           // R5
    run_xfer(32'h0040_0000, 32'h0050_0000, 16'h0F0F, 32'd3072, 1'b1, 0, 0);
    run_xfer(32'h0060_0010, 32'h0070_0020, 16'h1234, 32'd4500, 1'b0, 0, 0);
    stall_on = 1'b0;

    // R6: zero length completes with no command.
    push_cnt = 0;
    @(negedge clk);
    req_length = '0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(done == 1'b1 && busy == 1'b1, "R6", "zero-length done cycle", {done, busy}, 3);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6", "zero-length idle after", {done, busy}, 0);
    check(push_cnt == 0, "R6", "zero-length pushes", push_cnt, 0);
    check(err_flag == 1'b0, "R8", "err clear before intrusion", err_flag, 0);

    // R8: intrusion during a transfer, then a later transfer still accepted.
    run_xfer(32'h0100_0000, 32'h0200_0000, 16'h00AA, 32'd2500, 1'b1, 1, 1);
    run_xfer(32'h0300_0000, 32'h0400_0000, 16'h00BB, 32'd2048, 1'b0, 0, 1);
    check(err_flag == 1'b1, "R8", "err stays sticky", err_flag, 1);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule